// File: doc/BRIEF.md
# Prescaled Saturating Charge Accumulator

This block turns a stream of signed integration events into a 16-bit charge count. Each event is a one-cycle pulse with a direction bit. The events first pass through a bidirectional prescaler whose length is a power of two chosen by software. Each carry out of the prescaler, up or down, moves the main count by one. The count saturates at both ends instead of wrapping.

The count is compared on every clock, as an unsigned value, against a programmable upper limit and a programmable lower limit. The results are held in sticky status flags, and a third flag marks that the count sits at either end of its range. A charge-complete input can force the count to full scale. A shutdown bit stops counting. Software sees all state through a parallel byte-wide register port.

Reading the status register clears each flag whose cause has gone away. A flag whose condition still holds stays set.

Top module: `chg_accum_top`

Register map (8-bit bytes; multi-byte values are little-endian):

| Address | Content |
|---|---|
| 0 | control |
| 1 | status (read only) |
| 2, 3 | charge count, low and high byte |
| 4, 5 | upper limit, low and high byte |
| 6, 7 | lower limit, low and high byte |

Control fields: bits [2:0] hold the prescale exponent k. Bits [4:3] hold the pin mode (00 off, 01 charge-complete input, 10 alert). Bit 7 is shutdown. Bits 6:5 are stored but have no function.

Status fields: bit 0 is the range-end flag. Bit 1 is the above-upper-limit flag. Bit 2 is the below-lower-limit flag. Bit 7 is the identity bit and is constant 1. All other status bits read 0.

## Requirements
- R1: The prescaler holds a fraction of width k. Starting from a cleared fraction, the 2^k-th up event raises the count by one. A down event on a cleared fraction lowers the count by one at once. An up event followed by a down event leaves the count unchanged. With k=0, every event steps the count.
- R2: After reset the registers read as follows: count 7FFFh, control 17h (k=7, pin mode 10, shutdown 0), status 80h, upper limit FFFFh, lower limit 0000h.
- R3: The count never wraps. It holds at FFFFh on further up steps and at 0000h on further down steps. Between loads it changes by at most one per cycle.
- R4: Status bit 0 is set in the cycle after the count equals 0000h or FFFFh.
- R5: Status bit 1 is set in the cycle after the count is above the upper limit. Status bit 2 is set in the cycle after the count is below the lower limit. Both comparisons are unsigned 16-bit.
- R6: In pin mode 01, a high level on cc_in loads FFFFh into the count on the next edge. In any other pin mode, cc_in has no effect.
- R7: While control bit 7 is 1, events do not change the count and the prescaler fraction is cleared. All registers keep their values.
- R8: A status read returns the latched flags. It clears each flag whose condition is false at that edge and keeps each flag whose condition is true. Bit 7 always reads 1.
- R9: A host write to a count byte replaces only that byte. It takes priority over a same-cycle event step or charge-complete load, and it clears the prescaler fraction.
- R10: Each register byte can be written and read back at the address given in the register map.
- R11: A counted step is visible on charge_o one clock after the event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_vld | input | 1 | Integration event pulse |
| evt_up | input | 1 | Direction of the event: 1 means up |
| cc_in | input | 1 | Charge-complete level input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 1 clears flags |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| charge_o | output | 16 | Current charge count |

## Verification
The assertions check the following on every cycle:
- the count never wraps and moves by at most one between loads;
- the count stays frozen during shutdown;
- the charge-complete input forces full scale in its own pin mode;
- a byte write wins over a same-cycle step;
- the range-end and above-limit flags follow their conditions;
- the identity bit reads 1.

Only the bench scenarios can show the following:
- the exact prescaler event counts for several values of k;
- the loss of the fraction across shutdown and host writes;
- the clear-on-read behaviour in which a flag is kept while its cause persists;
- the unsigned comparison for counts above 7FFFh.

// File: rtl/chg_pkg.sv
package chg_pkg;
   localparam logic [2:0] ADR_CTRL   = 3'd0;
   localparam logic [2:0] ADR_STAT   = 3'd1;
   localparam logic [2:0] ADR_ACC_LO = 3'd2;
   localparam logic [2:0] ADR_HTH_LO = 3'd4;
   localparam logic [2:0] ADR_LTH_LO = 3'd6;

   localparam logic [7:0] CTRL_RST = 8'h17;

   localparam int ST_LIM = 0;
   localparam int ST_HI  = 1;
   localparam int ST_LO  = 2;
   localparam int ST_ID  = 7;

   typedef enum logic [1:0] {
      PIN_OFF   = 2'b00,
      PIN_CC    = 2'b01,
      PIN_ALERT = 2'b10,
      PIN_BAD   = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/chg_prescaler.sv
module chg_prescaler #(
   parameter int KW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          evt_vld,
   input  logic          evt_up,
   input  logic [KW-1:0] k,
   output logic          step_up,
   output logic          step_dn
);
   localparam int FRAC_W = (1 << KW) - 1;

   logic [FRAC_W-1:0] frac_q;
   logic [FRAC_W-1:0] mask;
   logic [FRAC_W-1:0] lowbits;

   // Only the low k bits of the fraction are in use for the current k.
   always_comb begin
      mask    = (FRAC_W'(1) << k) - FRAC_W'(1);
      lowbits = frac_q & mask;
      step_up = evt_vld &&  evt_up && (lowbits == mask);
      step_dn = evt_vld && !evt_up && (lowbits == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frac_q <= '0;
      else if (clr)
         frac_q <= '0;
      else if (evt_vld && evt_up)
         frac_q <= (frac_q + FRAC_W'(1)) & mask;
      else if (evt_vld)
         frac_q <= (frac_q - FRAC_W'(1)) & mask;
   end
endmodule

// File: rtl/chg_counter.sv
module chg_counter #(
   parameter int ACC_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up,
   input  logic              step_dn,
   input  logic              full_ld,
   input  logic [ACC_W/DATA_W-1:0] byte_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [ACC_W-1:0]  acc
);
   localparam int NB = ACC_W / DATA_W;
   localparam logic [ACC_W-1:0] ACC_RST = {1'b0, {(ACC_W-1){1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= ACC_RST;
      end else if (|byte_we) begin
         for (int b = 0; b < NB; b++)
            if (byte_we[b]) acc[b*DATA_W +: DATA_W] <= wdata;
      end else if (full_ld) begin
         acc <= '1;
      end else if (step_up && (acc != '1)) begin
         acc <= acc + ACC_W'(1);
      end else if (step_dn && (acc != '0)) begin
         acc <= acc - ACC_W'(1);
      end
   end
endmodule

// File: rtl/chg_flags.sv
module chg_flags #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] hth,
   input  logic [ACC_W-1:0] lth,
   input  logic             rd_clr,
   output logic [2:0]       flags
);
   logic [2:0] cond;

   always_comb begin
      cond[chg_pkg::ST_LIM] = (acc == '0) || (acc == '1);
      cond[chg_pkg::ST_HI]  = acc > hth;
      cond[chg_pkg::ST_LO]  = acc < lth;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags <= '0;
      else if (rd_clr) flags <= cond;
      else             flags <= flags | cond;
   end
endmodule

// File: rtl/chg_accum_top.sv
module chg_accum_top #(
   parameter int ACC_W  = 16,
   parameter int DATA_W = 8,
   parameter int KW     = 3,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_vld,
   input  logic              evt_up,
   input  logic              cc_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [ACC_W-1:0]  charge_o
);
   import chg_pkg::*;

   localparam int NB = ACC_W / DATA_W;

   if (ACC_W != 2 * DATA_W) begin : g_bad_width
      $error("chg_accum_top: ACC_W must be two bytes wide");
   end
   if (DATA_W != 8 || KW != 3 || ADDR_W != 3) begin : g_bad_map
      $error("chg_accum_top: register map needs 8-bit data, 3-bit k, 3-bit address");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [ACC_W-1:0]  hth_q, lth_q;
   logic [2:0]        flag_q;
   logic [NB-1:0]     acc_we;
   logic              shdn, full_ld, acc_load, step_up, step_dn;
   pin_mode_e         pin_mode;

   assign shdn     = ctrl_q[7];
   assign pin_mode = pin_mode_e'(ctrl_q[4:3]);
   assign full_ld  = (pin_mode == PIN_CC) && cc_in;

   for (genvar b = 0; b < NB; b++) begin : g_acc_we
      assign acc_we[b] = wr_en && (wr_addr == ADDR_W'(ADR_ACC_LO + b));
   end

   assign acc_load = (|acc_we) || full_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         hth_q  <= '1;
         lth_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL) ctrl_q <= wr_data;
         for (int b = 0; b < NB; b++) begin
            if (wr_addr == ADDR_W'(ADR_HTH_LO + b)) hth_q[b*DATA_W +: DATA_W] <= wr_data;
            if (wr_addr == ADDR_W'(ADR_LTH_LO + b)) lth_q[b*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end

   chg_prescaler #(.KW(KW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (shdn || acc_load),
      .evt_vld (evt_vld && !shdn),
      .evt_up  (evt_up),
      .k       (ctrl_q[KW-1:0]),
      .step_up (step_up),
      .step_dn (step_dn)
   );

   chg_counter #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_up (step_up),
      .step_dn (step_dn),
      .full_ld (full_ld),
      .byte_we (acc_we),
      .wdata   (wr_data),
      .acc     (charge_o)
   );

   chg_flags #(.ACC_W(ACC_W)) u_flg (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (charge_o),
      .hth    (hth_q),
      .lth    (lth_q),
      .rd_clr (rd_en && (rd_addr == ADR_STAT)),
      .flags  (flag_q)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADR_CTRL: rd_data = ctrl_q;
         ADR_STAT: begin
            rd_data[ST_ID]  = 1'b1;
            rd_data[ST_LIM] = flag_q[ST_LIM];
            rd_data[ST_HI]  = flag_q[ST_HI];
            rd_data[ST_LO]  = flag_q[ST_LO];
         end
         default: begin
            for (int b = 0; b < NB; b++) begin
               if (rd_addr == ADDR_W'(ADR_ACC_LO + b)) rd_data = charge_o[b*DATA_W +: DATA_W];
               if (rd_addr == ADDR_W'(ADR_HTH_LO + b)) rd_data = hth_q[b*DATA_W +: DATA_W];
               if (rd_addr == ADDR_W'(ADR_LTH_LO + b)) rd_data = lth_q[b*DATA_W +: DATA_W];
            end
         end
      endcase
   end
endmodule

// File: rtl/chg_accum_chk.sv
module chg_accum_chk #(
   parameter int ACC_W  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_vld,
   input logic              evt_up,
   input logic              cc_in,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [ACC_W-1:0]  charge,
   input logic [1:0]        mode,
   input logic              shdn,
   input logic [2:0]        k,
   input logic [ACC_W-1:0]  hth,
   input logic [2:0]        flags
);
   import chg_pkg::*;

   logic acc_wr, acc_load;
   assign acc_wr   = wr_en && (wr_addr == ADR_ACC_LO || wr_addr == ADDR_W'(ADR_ACC_LO + 1));
   assign acc_load = acc_wr || (mode == 2'b01 && cc_in);

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_load |=> (({1'b0, charge} - {1'b0, $past(charge)}) == '0 ||
                     ({1'b0, charge} - {1'b0, $past(charge)}) == (ACC_W+1)'(1) ||
                     ({1'b0, charge} - {1'b0, $past(charge)}) == '1)); // R3

   AST_SHDN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn && !acc_load) |=> $stable(charge)); // R7

   AST_CC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && cc_in && !acc_wr) |=> (charge == '1)); // R6

   AST_ID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADR_STAT) |-> rd_data[ST_ID]); // R8

   AST_HI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (charge > hth) |=> flags[ST_HI]); // R5

   AST_LIM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (charge == '1 || charge == '0) |=> flags[ST_LIM]); // R4

   AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_ACC_LO) |=> (charge[DATA_W-1:0] == $past(wr_data))); // R9

   AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && evt_up && !shdn && !acc_load && k == 3'd0 && charge != '1)
         |=> (charge == $past(charge) + ACC_W'(1))); // R11
endmodule

bind chg_accum_top chg_accum_chk #(.ACC_W(ACC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_vld (evt_vld),
   .evt_up  (evt_up),
   .cc_in   (cc_in),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .charge  (charge_o),
   .mode    (ctrl_q[4:3]),
   .shdn    (ctrl_q[7]),
   .k       (ctrl_q[2:0]),
   .hth     (hth_q),
   .flags   (flag_q)
);

// File: tb/chg_accum_top_tb.sv
module chg_accum_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_vld = 1'b0, evt_up = 1'b0, cc_in = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [15:0] charge_o;
   int          n_chk = 0, n_fail = 0;
   logic        done = 1'b0;
   logic [7:0]  d;

   always #10 clk = ~clk;

   chg_accum_top dut_i (
      .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_up(evt_up), .cc_in(cc_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .charge_o(charge_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic wr_acc(input logic [15:0] v);
      wr(3'd2, v[7:0]);
      wr(3'd3, v[15:8]);
   endtask

   task automatic pulse(input logic up, input int n);
      for (int i = 0; i < n; i++) begin
         evt_vld = 1'b1; evt_up = up;
         tick();
         evt_vld = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk("R2 count", charge_o, 16'h7FFF);
      rd(3'd0, d); chk("R2 control", {8'h0, d}, 16'h0017);
      rd(3'd1, d); chk("R2 status", {8'h0, d}, 16'h0080);
      rd(3'd4, d); chk("R2 upper lo", {8'h0, d}, 16'h00FF);
      rd(3'd5, d); chk("R2 upper hi", {8'h0, d}, 16'h00FF);
      rd(3'd6, d); chk("R2 lower lo", {8'h0, d}, 16'h0000);
      rd(3'd7, d); chk("R2 lower hi", {8'h0, d}, 16'h0000);
   endtask

   task automatic t_prescale();
      wr(3'd0, 8'h10);
      wr_acc(16'h1000);
      pulse(1'b1, 1); chk("R11 step next cycle", charge_o, 16'h1001);
      pulse(1'b1, 2); chk("R1 k=0 every event", charge_o, 16'h1003);
      wr(3'd0, 8'h12);
      wr_acc(16'h1000);
      pulse(1'b1, 3); chk("R1 k=2 three ups", charge_o, 16'h1000);
      pulse(1'b1, 1); chk("R1 k=2 fourth up", charge_o, 16'h1001);
      for (int i = 0; i < 4; i++) begin
         pulse(1'b1, 1);
         pulse(1'b0, 1);
      end
      chk("R1 up/down cancel", charge_o, 16'h1001);
      pulse(1'b0, 1); chk("R1 down from cleared", charge_o, 16'h1000);
      wr(3'd0, 8'h17);
      wr_acc(16'h1000);
      pulse(1'b1, 127); chk("R1 k=7 127 ups", charge_o, 16'h1000);
      pulse(1'b1, 1);   chk("R1 k=7 128th up", charge_o, 16'h1001);
   endtask

   task automatic t_saturate();
      wr(3'd0, 8'h10);
      wr_acc(16'hFFFE);
      pulse(1'b1, 1); chk("R3 reach top", charge_o, 16'hFFFF);
      pulse(1'b1, 1); chk("R3 hold top", charge_o, 16'hFFFF);
      rd(3'd1, d); chk("R4 top flag", {8'h0, d}, 16'h0081);
      pulse(1'b0, 1); chk("R3 leave top", charge_o, 16'hFFFE);
      rd(3'd1, d); chk("R8 sticky until read", {8'h0, d}, 16'h0081);
      rd(3'd1, d); chk("R8 cleared after read", {8'h0, d}, 16'h0080);
      wr_acc(16'h0001);
      pulse(1'b0, 1); chk("R3 reach bottom", charge_o, 16'h0000);
      pulse(1'b0, 1); chk("R3 hold bottom", charge_o, 16'h0000);
      rd(3'd1, d); chk("R4 bottom flag", {8'h0, d}, 16'h0081);
   endtask

   task automatic t_thresh();
      wr(3'd4, 8'h00); wr(3'd5, 8'h20);
      wr(3'd6, 8'h00); wr(3'd7, 8'h10);
      rd(3'd5, d); chk("R10 upper hi byte", {8'h0, d}, 16'h0020);
      rd(3'd7, d); chk("R10 lower hi byte", {8'h0, d}, 16'h0010);
      wr_acc(16'h1800);
      tick();
      rd(3'd1, d);
      rd(3'd1, d); chk("R5 inside window", {8'h0, d}, 16'h0080);
      wr_acc(16'h2001);
      tick();
      rd(3'd1, d); chk("R5 above upper", {8'h0, d}, 16'h0082);
      wr_acc(16'h0FFF);
      tick();
      rd(3'd1, d); chk("R8 both latched", {8'h0, d}, 16'h0086);
      rd(3'd1, d); chk("R8 persistent kept", {8'h0, d}, 16'h0084);
      wr_acc(16'h9000);
      tick();
      rd(3'd1, d);
      rd(3'd1, d); chk("R5 unsigned compare", {8'h0, d}, 16'h0082);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      wr(3'd6, 8'h00); wr(3'd7, 8'h00);
   endtask

   task automatic t_cc();
      wr(3'd0, 8'h08);
      wr_acc(16'h1234);
      cc_in = 1'b1; tick(); cc_in = 1'b0;
      chk("R6 load full in mode 01", charge_o, 16'hFFFF);
      wr(3'd0, 8'h10);
      wr_acc(16'h1234);
      cc_in = 1'b1; tick(); cc_in = 1'b0;
      chk("R6 ignored in mode 10", charge_o, 16'h1234);
      wr(3'd0, 8'h00);
      cc_in = 1'b1; tick(); cc_in = 1'b0;
      chk("R6 ignored in mode 00", charge_o, 16'h1234);
   endtask

   task automatic t_shdn();
      wr(3'd0, 8'h12);
      wr_acc(16'h3000);
      pulse(1'b1, 3);
      wr(3'd0, 8'h92);
      pulse(1'b1, 5); chk("R7 events ignored", charge_o, 16'h3000);
      rd(3'd0, d); chk("R7 control kept", {8'h0, d}, 16'h0092);
      wr(3'd0, 8'h12);
      pulse(1'b1, 1); chk("R7 fraction lost", charge_o, 16'h3000);
      pulse(1'b1, 3); chk("R7 counting resumes", charge_o, 16'h3001);
   endtask

   task automatic t_prio();
      wr(3'd0, 8'h10);
      wr_acc(16'h3001);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h50;
      evt_vld = 1'b1; evt_up = 1'b1;
      tick();
      wr_en = 1'b0; evt_vld = 1'b0;
      chk("R9 write beats step", charge_o, 16'h3050);
      wr(3'd0, 8'h12);
      wr_acc(16'h3000);
      pulse(1'b1, 3);
      wr(3'd2, 8'h00);
      pulse(1'b1, 1); chk("R9 write clears fraction", charge_o, 16'h3000);
      pulse(1'b1, 3); chk("R9 full period after write", charge_o, 16'h3001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_prescale();
      t_saturate();
      t_thresh();
      t_cc();
      t_shdn();
      t_prio();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule